// File: doc/BRIEF.md
# Bus Slave Transfer Control FSM

This block is the control state machine of a simple bus slave on a pipelined address/data system bus. It watches the slave-select, direction, upstream-ready and transfer-type inputs, recognises read and write requests, and steers a small register file through one read strobe, one write strobe and a captured address.

It always stretches the data phase by one wait cycle. When it accepts a request, it captures the address and direction and moves to a preparation state. In that state it drives its ready output low for exactly one cycle. It then enters a read or write state, which pulses the matching strobe with ready high. The response code is always OKAY. The three response bits (ready, code[1], code[0]) therefore read 100 when the slave is ready and 000 during the wait cycle.

Top module: `bus_slave_ctl`

## Requirements
- R1: While the active-low synchronous reset is applied, and on the first cycle after it is released, the block is asleep: ready is 1, both strobes are 0 and the captured address is 0.
- R2: A request is select=1, upstream-ready=1 and transfer type NSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) are not requests. While asleep, a non-request keeps the block asleep, with ready 1 and no strobe, on the next cycle.
- R3: A request seen while asleep, or while in a read or write state, makes ready 0 on the next cycle for exactly one cycle.
- R4: The cycle after the wait cycle has ready 1 and exactly one strobe. The read strobe is used if the request had direction 0, and the write strobe if it had direction 1.
- R5: The captured address equals the address present with the accepted request. It is shown during the wait cycle and during the strobe cycle.
- R6: In a read or write state, a non-request sends the block to sleep on the next cycle (ready 1, no strobe). A request sends it back to the wait cycle.
- R7: The response code output is always 2'b00 (OKAY).
- R8: The two strobes are never high together, and neither is high while ready is 0.
- R9: Inputs present during the wait cycle are ignored. They change neither the captured address nor the direction, nor the move into the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Slave select |
| bus_write | input | 1 | Transfer direction, 1 = write |
| bus_ready_in | input | 1 | Ready of the previous transfer on the bus |
| bus_trans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NSEQ, 11 SEQ |
| bus_addr | input | ADDR_W | Transfer address |
| rsp_ready | output | 1 | Slave ready (0 inserts a wait cycle) |
| rsp_code | output | 2 | Response code, always OKAY (00) |
| rf_rd_stb | output | 1 | Register-file read strobe |
| rf_wr_stb | output | 1 | Register-file write strobe |
| rf_addr | output | ADDR_W | Captured transfer address |

## Verification
Timing is counted from the clock edge that samples a request. Ready falls on the first cycle after that edge. The strobe and captured address are due on the second cycle. On the third cycle the block is either asleep again or back in a wait cycle, depending on the inputs held during the strobe cycle. The bench drives inputs just after a rising edge and samples the outputs one nanosecond after each later edge, so every check lands in the cycle it is due. All 32 combinations of the control inputs are swept once from the sleep state and once from a read state. In the second sweep, the same combination is applied during the wait cycle to show that those inputs are ignored.

// File: rtl/bus_slave_ctl.sv
module bus_slave_ctl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic              bus_ready_in,
  input  logic [1:0]        bus_trans,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rsp_ready,
  output logic [1:0]        rsp_code,
  output logic              rf_rd_stb,
  output logic              rf_wr_stb,
  output logic [ADDR_W-1:0] rf_addr
);

  typedef enum logic [1:0] {S_SLEEP, S_PREP, S_READ, S_WRITE} state_t;

  state_t            state, state_nx;
  logic              dir_q;
  logic [ADDR_W-1:0] addr_q;

  wire req    = bus_sel & bus_ready_in & bus_trans[1];
  wire accept = req & (state != S_PREP);

  always_comb begin
    state_nx = state;
    case (state)
      S_SLEEP:         if (req) state_nx = S_PREP;
      S_PREP:          state_nx = dir_q ? S_WRITE : S_READ;
      S_READ, S_WRITE: state_nx = req ? S_PREP : S_SLEEP;
      default:         state_nx = S_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_SLEEP;
      dir_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        dir_q  <= bus_write;
        addr_q <= bus_addr;
      end
    end
  end

  assign rsp_ready = (state != S_PREP);
  assign rsp_code  = 2'b00;
  assign rf_rd_stb = (state == S_READ);
  assign rf_wr_stb = (state == S_WRITE);
  assign rf_addr   = addr_q;

  p_wait_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |=> rsp_ready);
  p_req_gives_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && req) |=> !rsp_ready);
  p_wait_then_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |=> (rf_rd_stb || rf_wr_stb));
  p_idle_sleeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && !req) |=> (rsp_ready && !rf_rd_stb && !rf_wr_stb));
  p_addr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_ready |=> $stable(rf_addr));
  p_strobe_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd_stb || rf_wr_stb) |-> (rsp_ready && !(rf_rd_stb && rf_wr_stb)));

endmodule

// File: tb/bus_slave_ctl_bench.sv
module bus_slave_ctl_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_write = 1'b0, bus_ready_in = 1'b0;
  logic [1:0]    bus_trans = 2'b00;
  logic [AW-1:0] bus_addr = '0;
  logic          rsp_ready, rf_rd_stb, rf_wr_stb;
  logic [1:0]    rsp_code;
  logic [AW-1:0] rf_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bus_slave_ctl #(.ADDR_W(AW)) u_bus_slave_ctl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_ready_in(bus_ready_in), .bus_trans(bus_trans), .bus_addr(bus_addr),
    .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rf_rd_stb(rf_rd_stb),
    .rf_wr_stb(rf_wr_stb), .rf_addr(rf_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // packed view {ready, rd, wr}
  task automatic chk_out(input logic rdy, input logic rd, input logic wr, input string req);
    chk({rsp_ready, rf_rd_stb, rf_wr_stb} == {rdy, rd, wr}, req,
        {rsp_ready, rf_rd_stb, rf_wr_stb}, {rdy, rd, wr});
    chk(rsp_code == 2'b00, "R7", rsp_code, 0);
    chk(!(rf_rd_stb && rf_wr_stb) && !((rf_rd_stb || rf_wr_stb) && !rsp_ready),
        "R8", {rsp_ready, rf_rd_stb, rf_wr_stb}, 0);
  endtask

  task automatic drive(input int c, input logic [AW-1:0] a);
    {bus_sel, bus_write, bus_ready_in, bus_trans} = c[4:0];
    bus_addr = a;
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    drive(0, '0);
    tick();
    chk_out(1'b1, 1'b0, 1'b0, "R1");
    chk(rf_addr == '0, "R1", rf_addr, 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk_out(1'b1, 1'b0, 1'b0, "R1");
  endtask

  function automatic bit is_req(input int c);
    return c[4] && c[2] && c[1];
  endfunction

  initial begin
    #1;
    // Sweep 1: every control combination from sleep
    for (int c = 0; c < 32; c++) begin
      logic [AW-1:0] a;
      a = AW'(8'h10 + c * 3);
      do_reset();
      drive(c, a);
      tick();
      if (is_req(c)) begin
        chk_out(1'b0, 1'b0, 1'b0, "R3");
        chk(rf_addr == a, "R5", rf_addr, a);
        drive(0, '0);
        tick();
        chk_out(1'b1, !c[3], c[3], "R4");
        chk(rf_addr == a, "R5", rf_addr, a);
        tick();
        chk_out(1'b1, 1'b0, 1'b0, "R6");
      end else begin
        chk_out(1'b1, 1'b0, 1'b0, "R2");
        drive(0, '0);
        tick();
        chk_out(1'b1, 1'b0, 1'b0, "R2");
      end
    end

    // Sweep 2: combination held during the wait cycle and then the read state
    for (int c = 0; c < 32; c++) begin
      logic [AW-1:0] a;
      a = AW'(8'h80 + c);
      do_reset();
      drive(5'b10110, 8'h33);  // read request, NSEQ
      tick();
      chk_out(1'b0, 1'b0, 1'b0, "R3");
      drive(c, a);             // inputs during wait are ignored
      tick();
      chk_out(1'b1, 1'b1, 1'b0, "R9");
      chk(rf_addr == 8'h33, "R9", rf_addr, 8'h33);
      tick();
      if (is_req(c)) begin
        chk_out(1'b0, 1'b0, 1'b0, "R6");
        chk(rf_addr == a, "R5", rf_addr, a);
        drive(0, '0);
        tick();
        chk_out(1'b1, !c[3], c[3], "R4");
        chk(rf_addr == a, "R5", rf_addr, a);
      end else begin
        chk_out(1'b1, 1'b0, 1'b0, "R6");
        chk(rf_addr == 8'h33, "R5", rf_addr, 8'h33);
      end
    end

    // Back-to-back writes with SEQ
    do_reset();
    drive(5'b11111, 8'hA5);
    tick();
    chk_out(1'b0, 1'b0, 1'b0, "R3");
    tick();
    chk_out(1'b1, 1'b0, 1'b1, "R4");
    drive(5'b11111, 8'h5A);
    tick();
    chk_out(1'b0, 1'b0, 1'b0, "R6");
    chk(rf_addr == 8'h5A, "R5", rf_addr, 8'h5A);
    drive(0, '0);
    tick();
    chk_out(1'b1, 1'b0, 1'b1, "R4");
    tick();
    chk_out(1'b1, 1'b0, 1'b0, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule